// File: doc/BRIEF.md
# PWM Output Emergency Disable Controller

This block sits between a PWM timer and the pad tri-state controls of its output pins. It forces selected timer outputs into high impedance whenever an enabled fault source trips. It controls two pin groups. The first is a single-channel group of three pins, labelled A, B and C. The second is a complementary pair, labelled B and D.

There are five kinds of fault source:
- active-low external fault inputs, each digitally filtered;
- a shoot-through check that trips when both outputs of the complementary pair are at their active level at once;
- an oscillator-stop indication;
- a one-clock event-link pulse;
- a software shutdown request per group.

The four hardware sources latch into sticky flags. The software request is a plain level. Each pin's disable line is the OR of its enabled sources, masked by that pin's own enable. It is registered before it leaves the block. Software configures the enables, raises requests, and reads and clears the flags through a four-word register port.

Top module: `pwm_fault_shutdown`

## Requirements
- R1: While a pin's enable bit is 0, that pin's `hiz` bit is 0, whatever the flags or requests.
- R2: Each external fault input passes through two synchronizer flops and then a run counter. Its flag sets only after 16 consecutive low samples at the synchronizer output. For an input held low from just after clock edge 0, the flag is set at edge 18. A shorter low pulse sets no flag.
- R3: The single-group input flag puts pins A, B and C into high impedance only for pins whose enable is 1, and only while the single-group detect enable is 1.
- R4: The software request of a group puts every enabled pin of that group into high impedance without setting any flag.
- R5: The oscillator-stop flag is set on any clock where `osc_stop` is 1. It disables a pin of either group only when the oscillator detect enable and the pin enable are both 1.
- R6: Any of the three pair fault-input flags disables both pair pins when the pair enable is 1. The single-group pins are not affected by them.
- R7: The shoot-through flag is set on any clock where `pair_lvl_p` and `pair_lvl_n` both equal the active level (1 by default). It disables both pair pins only when the compare enable and the pair enable are both 1.
- R8: An `evt_pulse` sets the event flag, which disables every pin whose enable is 1.
- R9: Flags are sticky. A flag clears only when three conditions all hold:
  - software writes 0 to it;
  - a read strobe of the flag word has returned it as 1 since that read;
  - its source is no longer present.
  Writing 1, or clearing without that prior read, leaves it set. For an external input, "present" means its synchronized level is low.
- R10: A pin stays in high impedance until every contributing flag and request is clear. It is released on the clock after that.
- R11: `hiz` is registered. It changes on the clock edge after the edge that sets a flag or writes a request.
- R12: Register map at `reg_addr`. Unused bits read 0. Writes take effect at the clock edge of `reg_wr`. `reg_rdata` is combinational from `reg_addr`.

  | Address | Contents |
  |---|---|
  | 0 | Pin enables: bits 2:0 for pins A, B, C; bit 3 for the pair |
  | 1 | Source enables: bit 0 single-group detect, bit 1 compare, bit 2 oscillator-stop |
  | 2 | Software requests: bit 0 single group, bit 1 pair |
  | 3 | Flags: bit 0 single input; bits 3:1 pair inputs 0 to 2; bit 4 compare; bit 5 oscillator-stop; bit 6 event |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| solo_flt_n | input | 1 | Active-low fault input of the single group |
| pair_flt_n | input | 3 | Active-low fault inputs of the pair group |
| pair_lvl_p | input | 1 | Current level of pair output B |
| pair_lvl_n | input | 1 | Current level of pair output D |
| osc_stop | input | 1 | Oscillator-stop indication, active high |
| evt_pulse | input | 1 | Event-link shutdown pulse |
| reg_addr | input | 2 | Register word select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms flag clearing) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| hiz | output | 5 | Per-pin disable: bits 2:0 pins A, B, C; bits 4:3 pair pins B, D |

## Verification
An external fault input reaches its flag 18 edges after it falls, because the two synchronizer edges precede 16 counted samples. It reaches the pin one edge later. The bench checks both edges exactly: the flag just before and at edge 18, and the pin at edge 19.

The compare, oscillator-stop and event sources set their flag one edge after being driven and move `hiz` on the edge after that. A register write changes the pin on the edge following the write edge.

The bench drives on falling edges and reads at the falling edge after the counted rising edges. A random phase advances a bench model by one edge per step and compares `hiz` and the flag word at every step.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_PINEN = 2'd0,
        RA_SRCEN = 2'd1,
        RA_SWREQ = 2'd2,
        RA_FLAGS = 2'd3
    } reg_addr_e;

    // bit 0 solo detect, bit 1 compare, bit 2 oscillator stop
    typedef struct packed {
        logic osc_det;
        logic cmp_det;
        logic solo_det;
    } src_en_t;

    // bit 0 solo group, bit 1 pair group
    typedef struct packed {
        logic pair_grp;
        logic solo_grp;
    } sw_req_t;

    // flag word: [0] solo input, [P:1] pair inputs, then compare, osc, event
    function automatic int flag_count(input int pair_ins);
        return pair_ins + 4;
    endfunction

    function automatic int flag_cmp(input int pair_ins);
        return pair_ins + 1;
    endfunction

    function automatic int flag_osc(input int pair_ins);
        return pair_ins + 2;
    endfunction

    function automatic int flag_evt(input int pair_ins);
        return pair_ins + 3;
    endfunction

    function automatic int cnt_width(input int len);
        return (len <= 2) ? 1 : $clog2(len);
    endfunction

endpackage

// File: rtl/pfs_in_filter.sv
module pfs_in_filter #(
    parameter int FILT_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic low_now,
    output logic qualified
);
    localparam int            CW   = pfs_pkg::cnt_width(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_n};
            if (sync_q[1]) begin
                run_q <= '0;
            end else if (run_q != LAST) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign low_now   = ~sync_q[1];
    assign qualified = low_now && (run_q == LAST);

endmodule

// File: rtl/pfs_flag_bank.sv
module pfs_flag_bank #(
    parameter int NFLAG = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_v,
    input  logic [NFLAG-1:0] present_v,
    input  logic             flag_rd,
    input  logic             flag_wr,
    input  logic [NFLAG-1:0] wr_bits,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] armed_q;
    logic [NFLAG-1:0] clr_ok;

    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_bit
            // a clear needs a write of 0, a prior read as 1 and an absent source
            assign clr_ok[g] = flag_wr && !wr_bits[g] && armed_q[g] && !present_v[g];

            always_ff @(posedge clk) begin
                if (rst) begin
                    flags[g]   <= 1'b0;
                    armed_q[g] <= 1'b0;
                end else begin
                    flags[g] <= (flags[g] && !clr_ok[g]) || set_v[g];
                    if (flag_rd) begin
                        armed_q[g] <= flags[g];
                    end else if (clr_ok[g]) begin
                        armed_q[g] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pfs_regs.sv
module pfs_regs
    import pfs_pkg::*;
#(
    parameter int SOLO_PINS = 3,
    parameter int NFLAG     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [NFLAG-1:0]  flags,
    output logic [SOLO_PINS:0] pin_en,
    output src_en_t           src_en,
    output sw_req_t           sw_req,
    output logic              flag_wr,
    output logic              flag_rd,
    output logic [NFLAG-1:0]  flag_bits,
    output logic [REG_W-1:0]  reg_rdata
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_en <= '0;
            src_en <= '0;
            sw_req <= '0;
        end else if (reg_wr) begin
            case (sel)
                RA_PINEN: pin_en <= reg_wdata[SOLO_PINS:0];
                RA_SRCEN: src_en <= src_en_t'(reg_wdata[2:0]);
                RA_SWREQ: sw_req <= sw_req_t'(reg_wdata[1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            RA_PINEN: reg_rdata[SOLO_PINS:0] = pin_en;
            RA_SRCEN: reg_rdata[2:0]         = src_en;
            RA_SWREQ: reg_rdata[1:0]         = sw_req;
            RA_FLAGS: reg_rdata[NFLAG-1:0]   = flags;
            default:  reg_rdata              = '0;
        endcase
    end

    assign flag_wr   = reg_wr && (sel == RA_FLAGS);
    assign flag_rd   = reg_rd && (sel == RA_FLAGS);
    assign flag_bits = reg_wdata[NFLAG-1:0];

    generate
        if (NFLAG < REG_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^reg_wdata[REG_W-1:NFLAG];
        end
    endgenerate

endmodule

// File: rtl/pfs_pin_gate.sv
module pfs_pin_gate
    import pfs_pkg::*;
#(
    parameter int SOLO_PINS = 3,
    parameter int PAIR_INS  = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [flag_count(PAIR_INS)-1:0]  flags,
    input  logic [SOLO_PINS:0]               pin_en,
    input  src_en_t                          src_en,
    input  sw_req_t                          sw_req,
    output logic [SOLO_PINS+1:0]             hiz
);
    localparam int FC = flag_cmp(PAIR_INS);
    localparam int FO = flag_osc(PAIR_INS);
    localparam int FE = flag_evt(PAIR_INS);

    logic                 common_trip;
    logic                 solo_trip;
    logic                 pair_trip;
    logic [SOLO_PINS+1:0] hiz_d;

    assign common_trip = (src_en.osc_det && flags[FO]) || flags[FE];
    assign solo_trip   = common_trip || sw_req.solo_grp || (src_en.solo_det && flags[0]);
    assign pair_trip   = common_trip || sw_req.pair_grp || (src_en.cmp_det && flags[FC])
                       || (|flags[PAIR_INS:1]);

    generate
        for (genvar g = 0; g < SOLO_PINS; g++) begin : g_solo
            assign hiz_d[g] = pin_en[g] && solo_trip;
        end
        for (genvar g = 0; g < 2; g++) begin : g_pair
            assign hiz_d[SOLO_PINS+g] = pin_en[SOLO_PINS] && pair_trip;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hiz <= '0;
        end else begin
            hiz <= hiz_d;
        end
    end

endmodule

// File: rtl/pwm_fault_shutdown.sv
module pwm_fault_shutdown
    import pfs_pkg::*;
#(
    parameter int   SOLO_PINS = 3,
    parameter int   PAIR_INS  = 3,
    parameter int   FILT_LEN  = 16,
    parameter logic PAIR_ACT  = 1'b1,
    localparam int  NPIN      = SOLO_PINS + 2,
    localparam int  NFLAG     = flag_count(PAIR_INS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                solo_flt_n,
    input  logic [PAIR_INS-1:0] pair_flt_n,
    input  logic                pair_lvl_p,
    input  logic                pair_lvl_n,
    input  logic                osc_stop,
    input  logic                evt_pulse,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [NPIN-1:0]     hiz
);
    logic [PAIR_INS:0]  ext_n;
    logic [PAIR_INS:0]  ext_low;
    logic [PAIR_INS:0]  ext_hit;
    logic               pair_clash;
    logic [NFLAG-1:0]   set_v;
    logic [NFLAG-1:0]   present_v;
    logic [NFLAG-1:0]   flags_w;
    logic [NFLAG-1:0]   flag_bits_w;
    logic               flag_wr_w;
    logic               flag_rd_w;
    logic [SOLO_PINS:0] pin_en_w;
    src_en_t            src_en_w;
    sw_req_t            sw_w;

    assign ext_n = {pair_flt_n, solo_flt_n};

    generate
        for (genvar g = 0; g <= PAIR_INS; g++) begin : g_in
            pfs_in_filter #(
                .FILT_LEN(FILT_LEN)
            ) u_flt (
                .clk      (clk),
                .rst      (rst),
                .pin_n    (ext_n[g]),
                .low_now  (ext_low[g]),
                .qualified(ext_hit[g])
            );
        end
    endgenerate

    assign pair_clash = (pair_lvl_p == PAIR_ACT) && (pair_lvl_n == PAIR_ACT);
    assign set_v      = {evt_pulse, osc_stop, pair_clash, ext_hit};
    assign present_v  = {evt_pulse, osc_stop, pair_clash, ext_low};

    pfs_flag_bank #(
        .NFLAG(NFLAG)
    ) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_v    (set_v),
        .present_v(present_v),
        .flag_rd  (flag_rd_w),
        .flag_wr  (flag_wr_w),
        .wr_bits  (flag_bits_w),
        .flags    (flags_w)
    );

    pfs_regs #(
        .SOLO_PINS(SOLO_PINS),
        .NFLAG    (NFLAG)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .flags    (flags_w),
        .pin_en   (pin_en_w),
        .src_en   (src_en_w),
        .sw_req   (sw_w),
        .flag_wr  (flag_wr_w),
        .flag_rd  (flag_rd_w),
        .flag_bits(flag_bits_w),
        .reg_rdata(reg_rdata)
    );

    pfs_pin_gate #(
        .SOLO_PINS(SOLO_PINS),
        .PAIR_INS (PAIR_INS)
    ) u_gate (
        .clk   (clk),
        .rst   (rst),
        .flags (flags_w),
        .pin_en(pin_en_w),
        .src_en(src_en_w),
        .sw_req(sw_w),
        .hiz   (hiz)
    );

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
    import pfs_pkg::*;
#(
    parameter int   SOLO_PINS = 3,
    parameter int   NPIN      = 5,
    parameter int   NFLAG     = 7,
    parameter logic PAIR_ACT  = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [SOLO_PINS:0] pin_en,
    input logic [1:0]         sw_req,
    input logic [NFLAG-1:0]   flags,
    input logic [NPIN-1:0]    hiz,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               osc_stop,
    input logic               evt_pulse,
    input logic               pair_lvl_p,
    input logic               pair_lvl_n
);
    localparam int FC = NFLAG - 3;
    localparam int FO = NFLAG - 2;
    localparam int FE = NFLAG - 1;

    generate
        for (genvar g = 0; g < SOLO_PINS; g++) begin : g_off
            // R1
            solo_pin_off_chk: assert property (@(posedge clk) disable iff (rst)
                !pin_en[g] |=> !hiz[g]);
        end
    endgenerate

    // R1
    pair_pin_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_en[SOLO_PINS] |=> (hiz[NPIN-1:SOLO_PINS] == 2'b00));

    // R6
    pair_match_chk: assert property (@(posedge clk) disable iff (rst)
        hiz[SOLO_PINS] == hiz[SOLO_PINS+1]);

    // R4
    sw_solo_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_req[0] && pin_en[0]) |=> hiz[0]);

    // R4
    sw_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_req[1] && pin_en[SOLO_PINS]) |=> hiz[SOLO_PINS]);

    // R7
    clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_lvl_p == PAIR_ACT && pair_lvl_n == PAIR_ACT) |=> flags[FC]);

    // R8
    evt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |=> flags[FE]);

    // R9
    osc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[FO] && osc_stop) |=> flags[FO]);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == RA_FLAGS) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

bind pwm_fault_shutdown pfs_checker #(
    .SOLO_PINS(SOLO_PINS),
    .NPIN     (NPIN),
    .NFLAG    (NFLAG),
    .PAIR_ACT (PAIR_ACT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_en    (pin_en_w),
    .sw_req    (sw_w),
    .flags     (flags_w),
    .hiz       (hiz),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .osc_stop  (osc_stop),
    .evt_pulse (evt_pulse),
    .pair_lvl_p(pair_lvl_p),
    .pair_lvl_n(pair_lvl_n)
);

// File: tb/pwm_fault_shutdown_tb.sv
module pwm_fault_shutdown_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       solo_flt_n;
    logic [2:0] pair_flt_n;
    logic       pair_lvl_p;
    logic       pair_lvl_n;
    logic       osc_stop;
    logic       evt_pulse;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [4:0] hiz;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pwm_fault_shutdown u_dut (
        .clk       (clk),
        .rst       (rst),
        .solo_flt_n(solo_flt_n),
        .pair_flt_n(pair_flt_n),
        .pair_lvl_p(pair_lvl_p),
        .pair_lvl_n(pair_lvl_n),
        .osc_stop  (osc_stop),
        .evt_pulse (evt_pulse),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hiz       (hiz)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        step(1);
        reg_wr    = 1'b0;
    endtask

    task automatic arm();
        reg_addr = 2'd3;
        reg_rd   = 1'b1;
        step(1);
        reg_rd   = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // expected pin disables from enables, source enables, requests and flags
    function automatic logic [4:0] exp_hiz(input logic [3:0] pe, input logic [2:0] se,
                                           input logic [1:0] sw, input logic [6:0] f);
        logic com, solo, pair;
        com  = (se[2] & f[5]) | f[6];
        solo = com | sw[0] | (se[0] & f[0]);
        pair = com | sw[1] | (se[1] & f[4]) | f[1] | f[2] | f[3];
        return {{2{pe[3] & pair}}, pe[2:0] & {3{solo}}};
    endfunction

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [3:0] m_pe;
        logic [2:0] m_se;
        logic [1:0] m_sw;
        logic [6:0] m_f, m_arm, set_m, clr_m;
        logic [4:0] nh;
        int unsigned seed;

        seed = 32'd918273;
        void'($urandom(seed));
        rst = 1'b1; solo_flt_n = 1'b1; pair_flt_n = 3'b111;
        pair_lvl_p = 1'b0; pair_lvl_n = 1'b0; osc_stop = 1'b0; evt_pulse = 1'b0;
        reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
        step(3);
        rst = 1'b0;
        step(1);

        // reset state (R12)
        chk("R12 reset hiz", 32'(hiz), 32'h0);
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), rd);
            chk("R12 reset register", 32'(rd), 32'h0);
        end

        // random phase against a bench model (R11, R9)
        m_pe = '0; m_se = '0; m_sw = '0; m_f = '0; m_arm = '0;
        for (int i = 0; i < 1500; i++) begin
            int op;
            op = int'($urandom % 8);
            reg_wdata  = 8'($urandom);
            osc_stop   = ($urandom % 12) == 0;
            evt_pulse  = ($urandom % 25) == 0;
            pair_lvl_p = ($urandom % 2) == 0;
            pair_lvl_n = ($urandom % 3) == 0;
            reg_wr = 1'b0; reg_rd = 1'b0;
            if (op < 5) begin
                reg_addr = (op == 4) ? 2'd3 : 2'(op);
                if (op == 3) reg_rd = 1'b1; else reg_wr = 1'b1;
                if (op == 3) reg_addr = 2'd3;
            end
            nh    = exp_hiz(m_pe, m_se, m_sw, m_f);
            set_m = {evt_pulse, osc_stop, pair_lvl_p & pair_lvl_n, 4'b0000};
            clr_m = '0;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_pe = reg_wdata[3:0];
                    2'd1: m_se = reg_wdata[2:0];
                    2'd2: m_sw = reg_wdata[1:0];
                    default: clr_m = ~reg_wdata[6:0] & m_arm & ~set_m;
                endcase
            end
            if (reg_rd) m_arm = m_f; else m_arm = m_arm & ~clr_m;
            m_f = (m_f & ~clr_m) | set_m;
            step(1);
            reg_wr = 1'b0; reg_rd = 1'b0;
            chk("R11 random hiz", 32'(hiz), 32'(nh));
            peek(2'd3, rd);
            chk("R9 random flags", 32'(rd), 32'(m_f));
        end

        // return to idle
        osc_stop = 1'b0; evt_pulse = 1'b0; pair_lvl_p = 1'b0; pair_lvl_n = 1'b0;
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        arm(); wr(2'd3, 8'h00);
        step(1);
        peek(2'd3, rd);
        chk("R9 idle flags cleared", 32'(rd), 32'h0);
        chk("R10 idle hiz", 32'(hiz), 32'h0);

        // R2: short low pulse is filtered out
        wr(2'd0, 8'h07); wr(2'd1, 8'h01);
        solo_flt_n = 1'b0; step(12);
        solo_flt_n = 1'b1; step(5);
        peek(2'd3, rd);
        chk("R2 short pulse no flag", 32'(rd), 32'h0);

        // R2/R11: sustained low, flag at edge 18, pin at edge 19
        solo_flt_n = 1'b0;
        step(17);
        peek(2'd3, rd);
        chk("R2 flag not before edge 18", 32'(rd[0]), 32'h0);
        step(1);
        peek(2'd3, rd);
        chk("R2 flag at edge 18", 32'(rd[0]), 32'h1);
        chk("R11 pin still driven at edge 18", 32'(hiz), 32'h0);
        step(1);
        chk("R3 solo pins disabled", 32'(hiz), 32'h07);

        // R3: detect enable off releases the pins
        wr(2'd1, 8'h00); step(1);
        chk("R3 detect enable off", 32'(hiz), 32'h00);
        wr(2'd1, 8'h01); step(1);
        chk("R3 detect enable on", 32'(hiz), 32'h07);

        // R9: clearing rules
        wr(2'd3, 8'h00);
        peek(2'd3, rd);
        chk("R9 clear without read ignored", 32'(rd[0]), 32'h1);
        arm(); wr(2'd3, 8'h00);
        peek(2'd3, rd);
        chk("R9 clear while present ignored", 32'(rd[0]), 32'h1);
        solo_flt_n = 1'b1; step(3);
        wr(2'd3, 8'h01);
        peek(2'd3, rd);
        chk("R9 write of 1 ignored", 32'(rd[0]), 32'h1);
        wr(2'd3, 8'h00);
        peek(2'd3, rd);
        chk("R9 armed clear accepted", 32'(rd[0]), 32'h0);
        chk("R10 pin held until edge after clear", 32'(hiz), 32'h07);
        step(1);
        chk("R10 pin released", 32'(hiz), 32'h00);

        // R6: pair fault input 1
        wr(2'd0, 8'h0F);
        pair_flt_n = 3'b101;
        step(19);
        peek(2'd3, rd);
        chk("R6 pair flag bit 2", 32'(rd), 32'h04);
        chk("R6 pair pins only", 32'(hiz), 32'h18);
        pair_flt_n = 3'b111; step(3);
        arm(); wr(2'd3, 8'h00); step(1);
        chk("R6 pair released", 32'(hiz), 32'h00);

        // R7: shoot-through compare
        wr(2'd0, 8'h08); wr(2'd1, 8'h00);
        pair_lvl_p = 1'b1; pair_lvl_n = 1'b1;
        step(1);
        pair_lvl_p = 1'b0;
        peek(2'd3, rd);
        chk("R7 compare flag", 32'(rd), 32'h10);
        step(2);
        chk("R7 compare disabled", 32'(hiz), 32'h00);
        wr(2'd1, 8'h02); step(1);
        chk("R7 compare enabled", 32'(hiz), 32'h18);
        pair_lvl_n = 1'b0;
        arm(); wr(2'd3, 8'h00); step(1);
        chk("R7 compare released", 32'(hiz), 32'h00);

        // R4: software request without flag
        wr(2'd0, 8'h05); wr(2'd2, 8'h01); step(1);
        chk("R4 solo request", 32'(hiz), 32'h05);
        peek(2'd3, rd);
        chk("R4 no flag from request", 32'(rd), 32'h00);
        wr(2'd2, 8'h00); step(1);
        chk("R10 request release", 32'(hiz), 32'h00);

        // R8: event pulse
        wr(2'd0, 8'h0B);
        evt_pulse = 1'b1; step(1);
        evt_pulse = 1'b0; step(1);
        chk("R8 event disables enabled pins", 32'(hiz), 32'h1B);
        arm(); wr(2'd3, 8'h00); step(1);
        chk("R8 event released", 32'(hiz), 32'h00);

        // R5: oscillator stop
        wr(2'd0, 8'h0F); wr(2'd1, 8'h00);
        osc_stop = 1'b1; step(3);
        chk("R5 osc detect off", 32'(hiz), 32'h00);
        wr(2'd1, 8'h04); step(1);
        chk("R5 osc detect on", 32'(hiz), 32'h1F);
        osc_stop = 1'b0;
        arm(); wr(2'd3, 8'h00); step(1);
        chk("R5 osc released", 32'(hiz), 32'h00);

        // R1: all pin enables off
        wr(2'd0, 8'h00); wr(2'd2, 8'h03);
        evt_pulse = 1'b1; step(1); evt_pulse = 1'b0; step(2);
        chk("R1 disabled pins never tri-stated", 32'(hiz), 32'h00);

        // R12: readback masks unused bits
        wr(2'd0, 8'hFA);
        peek(2'd0, rd);
        chk("R12 pin enable readback", 32'(rd), 32'h0A);
        wr(2'd1, 8'hFF);
        peek(2'd1, rd);
        chk("R12 source enable readback", 32'(rd), 32'h07);

        finish_run();
    end

endmodule